// File: doc/BRIEF.md
# I2C Register-Write Master

This block writes configuration registers in a single slave device over a two-wire I2C bus. A one-cycle `start` pulse captures a 7-bit device address, a register address (one or two bytes) and a transfer mode. The block then sends a START condition, the device address with the direction bit set to write, the register address bytes, and one or more data bytes. It finishes with a STOP condition. It is meant to sit beside a small sequencer that steps through a table of register settings after power-up, for example to set up an audio codec.

The block generates SCL itself. It never drives SDA high: it pulls the line low through `sda_oe`, and an external open-drain pad drives the line when `sda_oe` is high. The pad returns the line level on `sda_in`, which the block samples at each acknowledge slot. Data bytes come through a request/valid handshake, one byte at a time, just before each byte is shifted out. This lets one register-address phase be followed by a burst of several bytes. No read transfers are made.

Top module: `i2c_wr_master`

## Requirements
- R1: After reset and whenever `busy` is low, `scl` is 1, `sda_oe` is 0 and `data_req` is 0.
- R2: A transfer is a START (SDA falls while SCL is high), then the first byte `{slave_addr, 1'b0}` (bit 0 = 0 means write), then the register address byte(s), then the data byte(s), then a STOP (SDA rises while SCL is high). Each byte is sent MSB first and is followed by a ninth clock. No other START or STOP appears inside the frame.
- R3: With `addr16` = 1 the register address is sent as two bytes, `reg_addr[15:8]` first and then `reg_addr[7:0]`. With `addr16` = 0 only `reg_addr[7:0]` is sent.
- R4: With `burst` = 0 exactly one data byte is sent, whatever the value of `burst_len`.
- R5: With `burst` = 1, `burst_len` data bytes are sent after the single register-address phase. A `burst_len` of 0 sends one byte.
- R6: Before each data byte, `data_req` stays high until `data_valid` is seen high on a rising clock edge. The `wr_data` present on that edge is the byte sent next. SCL stays low while `data_req` is high.
- R7: During the ninth clock of every byte, `sda_oe` is 0. If `sda_in` is high at that slot (NACK), `nack_err` is set, the block sends a STOP with no further bytes, and it returns to idle. `nack_err` holds until the next accepted `start`.
- R8: `busy` goes high on the cycle after an accepted `start`. `done` pulses for exactly one cycle, as `busy` falls, at the end of every transfer, including one ended by a NACK.
- R9: Every SCL high phase inside a frame lasts 2*QDIV clock cycles. A bit period is 4*QDIV cycles.
- R10: A `start` pulse while `busy` is high is ignored and does not change the transfer in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer (accepted only when idle) |
| slave_addr | input | 7 | Device address |
| reg_addr | input | 16 | Register address |
| addr16 | input | 1 | 1: two-byte register address, 0: one byte |
| burst | input | 1 | 1: burst of `burst_len` data bytes, 0: one byte |
| burst_len | input | LENW | Burst length in bytes (0 treated as 1) |
| wr_data | input | 8 | Next data byte |
| data_valid | input | 1 | `wr_data` is valid |
| data_req | output | 1 | Block is waiting for the next data byte |
| sda_in | input | 1 | Sampled SDA line level |
| scl | output | 1 | Serial clock |
| sda_oe | output | 1 | 1 pulls SDA low |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| nack_err | output | 1 | A NACK ended the last transfer |

## Verification
The bench sweeps both register-address widths against byte mode and burst lengths from 0 to 4. It also varies the number of cycles the data source stalls, so the byte count, the address byte order and the SCL hold-low behaviour are each separated from one another. A modelled slave decodes START, STOP and every byte from the bus lines and refuses the acknowledge at each byte position in turn. This shows whether the error path stops after exactly the right byte and whether the error flag clears at the next transfer. A second `start` fired in the middle of a frame shows whether the frame it interrupts is left intact.

// File: rtl/i2c_wr_master.sv
module i2c_wr_master #(
  parameter int QDIV = 250,
  parameter int LENW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [6:0]      slave_addr,
  input  logic [15:0]     reg_addr,
  input  logic            addr16,
  input  logic            burst,
  input  logic [LENW-1:0] burst_len,
  input  logic [7:0]      wr_data,
  input  logic            data_valid,
  output logic            data_req,
  input  logic            sda_in,
  output logic            scl,
  output logic            sda_oe,
  output logic            busy,
  output logic            done,
  output logic            nack_err
);
  localparam int QW = (QDIV > 1) ? $clog2(QDIV) : 1;

  typedef enum logic [2:0] {S_IDLE, S_STRT, S_BITS, S_WAIT, S_STOP} st_t;
  typedef enum logic [1:0] {P_DEV, P_HI, P_LO, P_DAT} ph_t;

  st_t             st;
  ph_t             ph;
  logic [QW-1:0]   qcnt;
  logic [1:0]      q;
  logic [3:0]      bitn;
  logic [7:0]      shreg;
  logic [15:0]     regq;
  logic            a16;
  logic [LENW-1:0] left;
  logic            ackbad;

  wire tick = (qcnt == QW'(QDIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= P_DEV; qcnt <= '0; q <= '0; bitn <= '0;
      shreg <= '0; regq <= '0; a16 <= 1'b0; left <= '0; ackbad <= 1'b0;
      done <= 1'b0; nack_err <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st <= S_STRT; ph <= P_DEV; qcnt <= '0; q <= '0; bitn <= '0;
          shreg <= {slave_addr, 1'b0};
          regq <= reg_addr; a16 <= addr16; nack_err <= 1'b0;
          left <= (burst && burst_len != '0) ? burst_len : LENW'(1);
        end
        S_WAIT: if (data_valid) begin
          shreg <= wr_data;
          st <= S_BITS;
        end
        default: if (!tick) qcnt <= qcnt + 1'b1;
        else begin
          qcnt <= '0;
          q <= q + 2'd1;
          if (st == S_BITS && bitn == 4'd8 && q == 2'd2) ackbad <= sda_in;
          if (q == 2'd3) begin
            case (st)
              S_STRT: st <= S_BITS;
              S_STOP: begin st <= S_IDLE; done <= 1'b1; end
              default: if (bitn != 4'd8) begin
                bitn <= bitn + 4'd1;
                shreg <= {shreg[6:0], 1'b0};
              end else begin
                bitn <= '0;
                if (ackbad) begin
                  nack_err <= 1'b1;
                  st <= S_STOP;
                end else case (ph)
                  P_DEV: if (a16) begin ph <= P_HI; shreg <= regq[15:8]; end
                         else begin ph <= P_LO; shreg <= regq[7:0]; end
                  P_HI:  begin ph <= P_LO; shreg <= regq[7:0]; end
                  P_LO:  begin ph <= P_DAT; st <= S_WAIT; end
                  default: if (left == LENW'(1)) st <= S_STOP;
                           else begin left <= left - 1'b1; st <= S_WAIT; end
                endcase
              end
            endcase
          end
        end
      endcase
    end
  end

  assign scl      = (st == S_IDLE) || (st == S_STRT) || ((st == S_BITS || st == S_STOP) && q[1]);
  assign sda_oe   = (st == S_STRT && q[1]) ||
                    (st == S_BITS && bitn != 4'd8 && !shreg[7]) ||
                    (st == S_STOP && q != 2'd3);
  assign busy     = (st != S_IDLE);
  assign data_req = (st == S_WAIT);
endmodule

module i2c_wr_master_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic scl,
  input logic sda_oe,
  input logic data_req,
  input logic data_valid,
  input logic nack_err
);
  // R1
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (scl && !sda_oe && !data_req));
  // R8
  done_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  // R8
  busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  // R6
  req_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_req |-> !scl);
  // R6
  req_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_req && data_valid) |=> !data_req);
  // R7
  nack_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nack_err) |-> busy);
endmodule

bind i2c_wr_master i2c_wr_master_chk chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .scl(scl), .sda_oe(sda_oe), .data_req(data_req),
  .data_valid(data_valid), .nack_err(nack_err)
);

// File: tb/i2c_wr_master_test.sv
module i2c_wr_master_test;
  localparam int CLK_PERIOD = 10;
  localparam int QDIV = 2;
  localparam int LENW = 3;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [6:0] slave_addr = '0;
  logic [15:0] reg_addr = '0;
  logic addr16 = 1'b0, burst = 1'b0;
  logic [LENW-1:0] burst_len = '0;
  logic [7:0] wr_data = '0;
  logic data_valid = 1'b0;
  logic data_req, scl, sda_oe, busy, done, nack_err;
  logic slv_drv = 1'b0;
  logic sda_line;

  assign sda_line = !sda_oe && !slv_drv;

  i2c_wr_master #(.QDIV(QDIV), .LENW(LENW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .slave_addr(slave_addr),
    .reg_addr(reg_addr), .addr16(addr16), .burst(burst), .burst_len(burst_len),
    .wr_data(wr_data), .data_valid(data_valid), .data_req(data_req),
    .sda_in(sda_line), .scl(scl), .sda_oe(sda_oe), .busy(busy),
    .done(done), .nack_err(nack_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int k);
    return 8'(k * 53 + 17);
  endfunction

  // slave model and data source, sampled away from the active edge
  logic pscl = 1'b1, psda = 1'b1;
  int bitc = 0, ncap = 0, nstart = 0, nstop = 0, ndone = 0, nack_at = -1;
  int hi = 0, hi_ok = 0, hi_bad = 0, req_bad = 0;
  int fk = 0, fbase = 0, stall = 0, dly = 0;
  logic [7:0] sh = '0;
  logic [7:0] cap [0:15];

  always @(negedge clk) begin
    if (done) ndone++;
    if (data_req && scl) req_bad++;
    if (scl && pscl && psda && !sda_line) begin nstart++; bitc = 0; hi_ok = 0; end
    else if (scl && pscl && !psda && sda_line) nstop++;
    if (scl && !pscl) begin
      hi = 1; hi_ok = 1;
      if (bitc < 8) sh = {sh[6:0], sda_line};
      bitc++;
      if (bitc == 8 && ncap < 16) begin cap[ncap] = sh; ncap++; end
      if (bitc == 9) bitc = 0;
    end else if (scl) hi++;
    if (!scl && pscl) begin
      if (hi_ok != 0 && hi != 2*QDIV) hi_bad++;
      slv_drv = (bitc == 8) && (ncap - 1 != nack_at);
    end
    pscl = scl; psda = sda_line;
    data_valid = 1'b0;
    if (data_req) begin
      if (dly >= stall) begin
        data_valid = 1'b1; wr_data = pat(fbase + fk); fk++; dly = 0;
      end else dly++;
    end
  end

  task automatic run(input logic [6:0] sa, input logic [15:0] ra, input bit a16,
                     input bit bm, input int len, input int stl, input int nk,
                     input bit restart);
    logic [7:0] e [0:15];
    int ne, nd, w;
    @(negedge clk);
    ncap = 0; nstart = 0; nstop = 0; ndone = 0; hi_bad = 0; req_bad = 0;
    fk = 0; fbase = fbase + 8; stall = stl; dly = 0; nack_at = nk;
    slave_addr = sa; reg_addr = ra; addr16 = a16; burst = bm;
    burst_len = LENW'(len); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R8 busy after start", busy, 1);
    if (restart) begin
      repeat (30) @(negedge clk);
      slave_addr = ~sa; reg_addr = ~ra; addr16 = ~a16; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      slave_addr = sa; reg_addr = ra; addr16 = a16;
    end
    w = 0;
    while (ndone == 0 && w < 20000) begin @(negedge clk); w++; end
    repeat (3) @(negedge clk);
    ne = 0;
    e[ne++] = {sa, 1'b0};
    if (a16) e[ne++] = ra[15:8];
    e[ne++] = ra[7:0];
    nd = (bm && len != 0) ? len : 1;
    for (int k = 0; k < nd; k++) e[ne++] = pat(fbase + k);
    if (nk >= 0) ne = nk + 1;
    chk(w < 20000, "R8 transfer completes", w, 0);
    chk(ncap == ne, "R2/R3/R4/R5 byte count", ncap, ne);
    for (int k = 0; k < ne && k < ncap; k++)
      chk(cap[k] == e[k], (restart ? "R10 byte unchanged" :
                           (k == 0 ? "R2 device byte" : "R3/R5 byte value")), cap[k], e[k]);
    chk(nstart == 1 && nstop == 1, "R2 single START and STOP", nstart*10 + nstop, 11);
    chk(ndone == 1, "R8 one done pulse", ndone, 1);
    chk(hi_bad == 0, "R9 SCL high length", hi_bad, 0);
    chk(req_bad == 0, "R6 SCL low while waiting", req_bad, 0);
    chk(nack_err == (nk >= 0), "R7 nack flag", nack_err, nk >= 0);
    chk(!busy && scl && !sda_oe, "R1 idle bus after transfer", {busy, scl, sda_oe}, 3'b010);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(!busy && scl && !sda_oe && !data_req && !done && !nack_err,
        "R1 reset state", {busy, scl, sda_oe, data_req, done, nack_err}, 6'b010000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && scl && !sda_oe, "R1 idle after reset", {busy, scl, sda_oe}, 3'b010);
    for (int a = 0; a < 2; a++)
      for (int m = 0; m < 2; m++)
        for (int len = 0; len < 5; len++)
          run(7'h3B - 7'(len), 16'h4000 + 16'(len * 257), a[0], m[0], len, len % 3, -1, 1'b0);
    for (int nk = 0; nk < 5; nk++) begin
      run(7'h1A, 16'hC30C, 1'b1, 1'b1, 2, 1, nk, 1'b0);
      repeat (20) @(negedge clk);
      chk(nack_err == 1'b1, "R7 nack flag holds while idle", nack_err, 1);
    end
    run(7'h55, 16'h00A7, 1'b0, 1'b0, 3, 0, -1, 1'b0);
    run(7'h2C, 16'h9A5E, 1'b1, 1'b1, 3, 2, -1, 1'b1);
    run(7'h71, 16'h1234, 1'b0, 1'b1, 7, 0, -1, 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule